// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 16-bit data ports, A and B, through a non-inverting link that is split into two independent 8-bit groups. Each group has its own enable, direction, a pair of capture strobes and a pair of source selects. For each direction there is a storage register. When a group is enabled, exactly one of its two ports is driven. That port carries either live data from the opposite port or the value held in the register for that direction.

Each tri-state bus is modelled as three vectors: an input, an output and a per-bit output enable. This keeps the block synthesizable. The capture strobes are level signals. The system clock samples them, and a capture takes place on the first clock at which a strobe reads high after it read low on the previous clock. After reset a strobe counts as low. The registers keep capturing whatever the state of the enables, so a group can load data while it is isolated. The link carries no data stream and has no handshake: every pin is a plain control or data level. The output data vectors always carry the selected value, and the enable vectors alone decide whether a port is driven.

Top module: `dual_reg_xcvr`

## Requirements
- R1: The two 8-bit groups are fully independent. Group g uses bits [8g+7:8g] of every data vector and bit g of every control vector, and the controls of one group never affect the other group's outputs or registers.
- R2: When the A-to-B capture strobe of a group reads 1 at a clock edge after reading 0 at the previous edge, that group's A input is stored in its A-to-B register at that edge.
- R3: When the B-to-A capture strobe of a group rises in the same sampled sense, that group's B input is stored in its B-to-A register at that edge.
- R4: When the active-low enable `oe_n` of a group is 1 (isolation), every bit of that group's `a_oe` and `b_oe` is 0.
- R5: When `oe_n` is 0, `dir` = 1 sets all of the group's `b_oe` bits and clears its `a_oe` bits, and `dir` = 0 does the reverse. Both ports of a group are never enabled at once.
- R6: A select of 0 (`sel_ab` for port B, `sel_ba` for port A) passes the opposite port's live input through to the output in the same cycle, without inversion.
- R7: A select of 1 drives the output from that direction's register.
- R8: Captures take place during isolation, while the group drives the other way, and into both registers on the same edge.
- R9: A strobe held high for several clocks captures only once. The stored value does not change until the next rising transition.
- R10: While `rst_n` is 0, both registers of every group read 0 and all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the capture strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 2 | Per group: 1 drives port B, 0 drives port A |
| oe_n | input | 2 | Per group active-low output enable |
| cap_ab | input | 2 | Per group A-to-B capture strobe |
| cap_ba | input | 2 | Per group B-to-A capture strobe |
| sel_ab | input | 2 | Per group port-B source: 0 live A, 1 stored |
| sel_ba | input | 2 | Per group port-A source: 0 live B, 1 stored |
| a_in | input | 16 | Value seen on port A |
| a_out | output | 16 | Value offered to port A |
| a_oe | output | 16 | Per-bit drive enable for port A |
| b_in | input | 16 | Value seen on port B |
| b_out | output | 16 | Value offered to port B |
| b_oe | output | 16 | Per-bit drive enable for port B |

## Verification
Live pass-through is applied with distinct bit patterns on both ports so that a swapped, inverted or stale path shows up. Stored mode is tried after a capture followed by a change of the live input, which separates the register value from the live value. Captures are made while isolated, while driving the opposite way, and into both registers at once. A strobe is held high across several clocks to separate edge capture from level capture. The two groups receive different controls on the same cycle, and a reset in mid-run must clear values that were captured earlier.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_GROUPS  = 2;
  localparam int unsigned XCVR_GROUP_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  typedef enum logic {
    DRIVE_A = 1'b0,
    DRIVE_B = 1'b1
  } drive_side_e;
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = XCVR_GROUP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_i,
  input  logic             oe_n_i,
  input  logic             cap_ab_i,
  input  logic             cap_ba_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic [WIDTH-1:0] a_oe_o,
  output logic [WIDTH-1:0] b_out_o,
  output logic [WIDTH-1:0] b_oe_o
);
  logic             rise_ab, rise_ba;
  logic [WIDTH-1:0] hold_ab_q, hold_ba_q;
  logic             drive_en;
  drive_side_e      side;
  src_sel_e         src_b, src_a;

  xcvr_rise_det u_det_ab (.clk(clk), .rst_n(rst_n), .level_i(cap_ab_i), .rise_o(rise_ab));
  xcvr_rise_det u_det_ba (.clk(clk), .rst_n(rst_n), .level_i(cap_ba_i), .rise_o(rise_ba));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ab_q <= '0;
      hold_ba_q <= '0;
    end else begin
      if (rise_ab) hold_ab_q <= a_in_i;
      if (rise_ba) hold_ba_q <= b_in_i;
    end
  end

  assign side  = drive_side_e'(dir_i);
  assign src_b = src_sel_e'(sel_ab_i);
  assign src_a = src_sel_e'(sel_ba_i);

  always_comb begin
    b_out_o = (src_b == SRC_STORED) ? hold_ab_q : a_in_i;
    a_out_o = (src_a == SRC_STORED) ? hold_ba_q : b_in_i;
  end

  assign drive_en = rst_n & ~oe_n_i;

  always_comb begin
    a_oe_o = '0;
    b_oe_o = '0;
    if (drive_en) begin
      if (side == DRIVE_B) b_oe_o = '1;
      else                 a_oe_o = '1;
    end
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned GROUPS  = XCVR_GROUPS,
  parameter int unsigned GROUP_W = XCVR_GROUP_W,
  localparam int unsigned W      = GROUPS * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUPS-1:0] dir,
  input  logic [GROUPS-1:0] oe_n,
  input  logic [GROUPS-1:0] cap_ab,
  input  logic [GROUPS-1:0] cap_ba,
  input  logic [GROUPS-1:0] sel_ab,
  input  logic [GROUPS-1:0] sel_ba,
  input  logic [W-1:0]      a_in,
  output logic [W-1:0]      a_out,
  output logic [W-1:0]      a_oe,
  input  logic [W-1:0]      b_in,
  output logic [W-1:0]      b_out,
  output logic [W-1:0]      b_oe
);
  // R1: one self-contained group per slice
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    xcvr_group #(.WIDTH(GROUP_W)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_i    (dir[g]),
      .oe_n_i   (oe_n[g]),
      .cap_ab_i (cap_ab[g]),
      .cap_ba_i (cap_ba[g]),
      .sel_ab_i (sel_ab[g]),
      .sel_ba_i (sel_ba[g]),
      .a_in_i   (a_in[g*GROUP_W +: GROUP_W]),
      .b_in_i   (b_in[g*GROUP_W +: GROUP_W]),
      .a_out_o  (a_out[g*GROUP_W +: GROUP_W]),
      .a_oe_o   (a_oe[g*GROUP_W +: GROUP_W]),
      .b_out_o  (b_out[g*GROUP_W +: GROUP_W]),
      .b_oe_o   (b_oe[g*GROUP_W +: GROUP_W])
    );
  end
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int unsigned GROUPS  = 2,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned W      = GROUPS * GROUP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GROUPS-1:0] dir,
  input logic [GROUPS-1:0] oe_n,
  input logic [GROUPS-1:0] cap_ab,
  input logic [GROUPS-1:0] cap_ba,
  input logic [GROUPS-1:0] sel_ab,
  input logic [GROUPS-1:0] sel_ba,
  input logic [W-1:0]      a_in,
  input logic [W-1:0]      a_out,
  input logic [W-1:0]      a_oe,
  input logic [W-1:0]      b_in,
  input logic [W-1:0]      b_out,
  input logic [W-1:0]      b_oe
);
  logic [GROUPS-1:0] seen_ab, seen_ba;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ab <= '0;
      seen_ba <= '0;
    end else begin
      seen_ab <= cap_ab;
      seen_ba <= cap_ba;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    assert_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[g] |-> (a_oe[g*GROUP_W +: GROUP_W] == '0 && b_oe[g*GROUP_W +: GROUP_W] == '0));

    assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe[g*GROUP_W] && b_oe[g*GROUP_W]));

    assert_live_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ab[g] |-> b_out[g*GROUP_W +: GROUP_W] == a_in[g*GROUP_W +: GROUP_W]);

    assert_capture_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ab[g] && !seen_ab[g]) |=>
        (!sel_ab[g] || b_out[g*GROUP_W +: GROUP_W] == $past(a_in[g*GROUP_W +: GROUP_W])));

    assert_capture_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ba[g] && !seen_ba[g]) |=>
        (!sel_ba[g] || a_out[g*GROUP_W +: GROUP_W] == $past(b_in[g*GROUP_W +: GROUP_W])));

    assert_hold_ab_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ab[g] && !(cap_ab[g] && !seen_ab[g])) |=>
        (!sel_ab[g] || $stable(b_out[g*GROUP_W +: GROUP_W])));
  end
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .oe_n(oe_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/dual_reg_xcvr_tb_top.sv
module dual_reg_xcvr_tb_top;
  localparam int G  = 2;
  localparam int GW = 8;
  localparam int W  = G * GW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [G-1:0] dir = '0, oe_n = '1, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  always #5 clk = ~clk;

  dual_reg_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .dir(dir), .oe_n(oe_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct {
    logic [W-1:0] ao, aoe, bo, boe;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic [G-1:0] p_ab = '0, p_ba = '0;

  task automatic apply(input logic rst, input logic [G-1:0] d, input logic [G-1:0] oen,
                       input logic [G-1:0] cab, input logic [G-1:0] cba,
                       input logic [G-1:0] sab, input logic [G-1:0] sba,
                       input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rst; dir = d; oe_n = oen; cap_ab = cab; cap_ba = cba;
    sel_ab = sab; sel_ba = sba; a_in = a; b_in = b;
    @(posedge clk);
    if (!rst) begin
      m_ab = '0; m_ba = '0; p_ab = '0; p_ba = '0;
    end else begin
      for (int g = 0; g < G; g++) begin
        if (cab[g] && !p_ab[g]) m_ab[g*GW +: GW] = a[g*GW +: GW];
        if (cba[g] && !p_ba[g]) m_ba[g*GW +: GW] = b[g*GW +: GW];
        p_ab[g] = cab[g];
        p_ba[g] = cba[g];
      end
    end
    #2;
    for (int g = 0; g < G; g++) begin
      logic en;
      en = rst && !oen[g];
      e.boe[g*GW +: GW] = (en && d[g])  ? '1 : '0;
      e.aoe[g*GW +: GW] = (en && !d[g]) ? '1 : '0;
      e.bo[g*GW +: GW]  = sab[g] ? m_ab[g*GW +: GW] : a[g*GW +: GW];
      e.ao[g*GW +: GW]  = sba[g] ? m_ba[g*GW +: GW] : b[g*GW +: GW];
    end
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      wait (sb.size() != 0);
      e = sb.pop_front();
      vectors++;
      if (b_oe !== e.boe) begin fails++; $display("FAIL %s: b_oe=%h exp %h", e.tag, b_oe, e.boe); end
      if (a_oe !== e.aoe) begin fails++; $display("FAIL %s: a_oe=%h exp %h", e.tag, a_oe, e.aoe); end
      if (b_out !== e.bo) begin fails++; $display("FAIL %s: b_out=%h exp %h", e.tag, b_out, e.bo); end
      if (a_out !== e.ao) begin fails++; $display("FAIL %s: a_out=%h exp %h", e.tag, a_out, e.ao); end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state, registers zero and enables off
    apply(1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'hA5A5, 16'h5A5A, "R10 reset");
    // R6 R5: live A to B, non-inverting
    apply(1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'hFEDC, "R6 R5 live A->B");
    // R6 R5: live B to A
    apply(1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h0F0F, 16'hC3A1, "R6 R5 live B->A");
    // R2 R7: capture A into A-to-B register of group 0
    apply(1'b1, 2'b01, 2'b10, 2'b01, 2'b00, 2'b01, 2'b00, 16'h005A, 16'h0000, "R2 capture AB");
    // R9: strobe held high, live A changes, stored stays
    apply(1'b1, 2'b01, 2'b10, 2'b01, 2'b00, 2'b01, 2'b00, 16'h00E7, 16'h0000, "R9 held strobe");
    apply(1'b1, 2'b01, 2'b10, 2'b01, 2'b00, 2'b01, 2'b00, 16'h0099, 16'h0000, "R9 held strobe 2");
    // R4 R8 R3: isolation, capture B into B-to-A register
    apply(1'b1, 2'b00, 2'b11, 2'b00, 2'b01, 2'b00, 2'b00, 16'h0011, 16'h003C, "R4 R8 R3 isolated capture");
    // R7 R3: drive A from stored
    apply(1'b1, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b01, 16'h0022, 16'h00FF, "R7 R3 stored B->A");
    // R8: capture both registers at once while driving B
    apply(1'b1, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01, 2'b01, 16'h0081, 16'h0042, "R8 dual capture");
    apply(1'b1, 2'b01, 2'b10, 2'b00, 2'b00, 2'b01, 2'b01, 16'h0000, 16'h0000, "R8 dual capture readback");
    // R1: groups get different controls on the same cycle
    apply(1'b1, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01, 2'b10, 16'hB7C4, 16'h6D29, "R1 split groups");
    apply(1'b1, 2'b01, 2'b01, 2'b00, 2'b00, 2'b11, 2'b11, 16'h0000, 16'hFFFF, "R1 split readback");
    // R10: mid-run reset clears captured values
    apply(1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'h1111, 16'h2222, "R10 mid reset");
    apply(1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'h3333, 16'h4444, "R10 after reset");
    // mixed patterns: R1 R2 R3 R5 R6 R7
    for (int i = 0; i < 60; i++) begin
      apply(1'b1, G'($urandom), G'($urandom), G'($urandom), G'($urandom), G'($urandom),
            G'($urandom), W'($urandom), W'($urandom), "R1 R2 R3 R6 R7 mixed");
    end
    wait (sb.size() == 0);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule